// File: doc/BRIEF.md
# Iterative Unit Occupancy Tracker

This block keeps track of how long the long-running arithmetic resources of an issue stage remain tied up once an operation has been launched on them. Three resources are tracked: the integer multiply/divide iterator, the floating-point multiply iterator and the floating-point divide/square-root iterator. Each one has its own down-counter. The arithmetic datapaths are not part of this block.

A request arrives as a single-cycle `op_start` together with an operation class and an operand-size bit. The block decodes which resource the operation needs, how many cycles that resource stays occupied and how many cycles the result takes. An accepted request loads the matching counter. That resource's busy flag stays high until its counter reaches zero. While the flag is high, any request aimed at the same resource is refused in the same cycle through `stall`. On every accepted request the block registers a result report one cycle later, carrying the result latency. The issue logic uses this report to schedule dependants.

Top module: `itr_occ_tracker`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy` is 3'b000 and `res_vld` is 0. This holds even if a resource was occupied when reset was applied.
- R2: Operation class 0 (integer divide) uses the integer iterator, with `busy` bit 0. It occupies the iterator for 36 cycles when `op_wide`=0 and 68 cycles when `op_wide`=1. The reported latency equals the occupancy.
- R3: Class 1 (integer multiply or multiply-accumulate) uses the integer iterator. It occupies it for 3 cycles with latency 5 when narrow, and for 8 cycles with latency 9 when wide.
- R4: Class 2 (three-operand multiply) holds the integer iterator for 2 stall cycles and reports latency 2 when narrow. When wide it behaves as in R3: 8 cycles of occupancy, latency 9.
- R5: Class 3 (FP divide or square root) uses the divide/square-root iterator, with `busy` bit 2. It occupies it for 21 cycles in single precision (`op_wide`=0) and 36 cycles in double precision. The latency equals the occupancy.
- R6: Class 4 (FP reciprocal square root) uses the divide/square-root iterator for 38 cycles in single precision and 68 in double. The latency equals the occupancy.
- R7: Class 5 (FP multiply or multiply-add) uses the multiply iterator, with `busy` bit 1. It occupies it for 1 cycle with latency 4 in single precision, and for 2 cycles with latency 5 in double.
- R8: Class 6 (move into the product register) reports latency 3. Class 7 (move out of it) reports latency 1. Neither class occupies an iterator, and neither is ever stalled.
- R9: A request whose resource has a nonzero counter raises `stall` in the same cycle and is dropped: no result report follows and the counter keeps counting down. A resource loaded with N cycles refuses exactly N consecutive requests that follow the accepting edge.
- R10: The three resources are independent. A busy resource never stalls a request aimed at another resource.
- R11: One cycle after an accepted request, `res_vld` is 1 for one cycle and `res_lat` holds that request's latency. In every other cycle `res_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | Request to launch an operation this cycle |
| op_class | input | 3 | Operation class, encoded 0 to 7 as listed in R2 to R8 |
| op_wide | input | 1 | 1 selects 64-bit or double-precision operands |
| stall | output | 1 | Request refused because its resource is occupied |
| busy | output | 3 | Occupied flags: bit 0 integer, bit 1 FP multiply, bit 2 FP divide/sqrt |
| res_vld | output | 1 | Result report valid, one cycle after acceptance |
| res_lat | output | 7 | Result latency of the accepted operation, in cycles |

## Verification
The assertions assume that `op_start` is a clean level sampled at the clock edge and that at most one request is presented per cycle. They also assume the latency and occupancy parameters fit in the counter width. The bench changes its inputs only just after the falling edge and holds them for a full cycle. Every operation class at both sizes is applied from an idle state after a reset, and the refusal window is probed by repeating the same request each cycle. A separate sequence keeps one resource occupied while requests for the other resources and the register moves are applied, so stalls are only ever provoked on the resource that is actually busy.

// File: rtl/itr_occ_pkg.sv
package itr_occ_pkg;

  localparam int NRES = 3;

  typedef enum logic [2:0] {
    OPC_IDIV  = 3'd0,
    OPC_IMUL  = 3'd1,
    OPC_IMUL3 = 3'd2,
    OPC_FDIV  = 3'd3,
    OPC_FRSQ  = 3'd4,
    OPC_FMUL  = 3'd5,
    OPC_MTPR  = 3'd6,
    OPC_MFPR  = 3'd7
  } opc_t;

  localparam int UNIT_INT  = 0;
  localparam int UNIT_FMUL = 1;
  localparam int UNIT_FDIV = 2;

endpackage

// File: rtl/itr_occ_decode.sv
module itr_occ_decode
  import itr_occ_pkg::*;
#(
  parameter int CNT_W       = 7,
  parameter int IDIV_N_CYC  = 36,
  parameter int IDIV_W_CYC  = 68,
  parameter int IMUL_N_CYC  = 3,
  parameter int IMUL_N_LAT  = 5,
  parameter int IMUL_W_CYC  = 8,
  parameter int IMUL_W_LAT  = 9,
  parameter int IMUL3_HOLD  = 2,
  parameter int IMUL3_LAT   = 2,
  parameter int FDIV_S_CYC  = 21,
  parameter int FDIV_D_CYC  = 36,
  parameter int FRSQ_S_CYC  = 38,
  parameter int FRSQ_D_CYC  = 68,
  parameter int FMUL_S_CYC  = 1,
  parameter int FMUL_S_LAT  = 4,
  parameter int FMUL_D_CYC  = 2,
  parameter int FMUL_D_LAT  = 5,
  parameter int MTPR_LAT    = 3,
  parameter int MFPR_LAT    = 1
) (
  input  logic [2:0]       opc,
  input  logic             wide,
  output logic [NRES-1:0]  unit_sel,
  output logic [CNT_W-1:0] occ,
  output logic [CNT_W-1:0] lat
);

  opc_t op;

  always_comb begin
    op       = opc_t'(opc);
    unit_sel = '0;
    occ      = '0;
    lat      = '0;
    case (op)
      OPC_IDIV: begin
        unit_sel[UNIT_INT] = 1'b1;
        occ = wide ? CNT_W'(IDIV_W_CYC) : CNT_W'(IDIV_N_CYC);
        lat = occ;
      end
      OPC_IMUL: begin
        unit_sel[UNIT_INT] = 1'b1;
        occ = wide ? CNT_W'(IMUL_W_CYC) : CNT_W'(IMUL_N_CYC);
        lat = wide ? CNT_W'(IMUL_W_LAT) : CNT_W'(IMUL_N_LAT);
      end
      OPC_IMUL3: begin
        unit_sel[UNIT_INT] = 1'b1;
        occ = wide ? CNT_W'(IMUL_W_CYC) : CNT_W'(IMUL3_HOLD);
        lat = wide ? CNT_W'(IMUL_W_LAT) : CNT_W'(IMUL3_LAT);
      end
      OPC_FDIV: begin
        unit_sel[UNIT_FDIV] = 1'b1;
        occ = wide ? CNT_W'(FDIV_D_CYC) : CNT_W'(FDIV_S_CYC);
        lat = occ;
      end
      OPC_FRSQ: begin
        unit_sel[UNIT_FDIV] = 1'b1;
        occ = wide ? CNT_W'(FRSQ_D_CYC) : CNT_W'(FRSQ_S_CYC);
        lat = occ;
      end
      OPC_FMUL: begin
        unit_sel[UNIT_FMUL] = 1'b1;
        occ = wide ? CNT_W'(FMUL_D_CYC) : CNT_W'(FMUL_S_CYC);
        lat = wide ? CNT_W'(FMUL_D_LAT) : CNT_W'(FMUL_S_LAT);
      end
      OPC_MTPR: lat = CNT_W'(MTPR_LAT);
      OPC_MFPR: lat = CNT_W'(MFPR_LAT);
      default: ;
    endcase
  end

endmodule

// File: rtl/itr_occ_counter.sv
module itr_occ_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             busy
);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/itr_occ_tracker.sv
module itr_occ_tracker
  import itr_occ_pkg::*;
#(
  parameter int CNT_W      = 7,
  parameter int IDIV_N_CYC = 36,
  parameter int IDIV_W_CYC = 68,
  parameter int IMUL_N_CYC = 3,
  parameter int IMUL_N_LAT = 5,
  parameter int IMUL_W_CYC = 8,
  parameter int IMUL_W_LAT = 9,
  parameter int IMUL3_HOLD = 2,
  parameter int IMUL3_LAT  = 2,
  parameter int FDIV_S_CYC = 21,
  parameter int FDIV_D_CYC = 36,
  parameter int FRSQ_S_CYC = 38,
  parameter int FRSQ_D_CYC = 68,
  parameter int FMUL_S_CYC = 1,
  parameter int FMUL_S_LAT = 4,
  parameter int FMUL_D_CYC = 2,
  parameter int FMUL_D_LAT = 5,
  parameter int MTPR_LAT   = 3,
  parameter int MFPR_LAT   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_start,
  input  logic [2:0]       op_class,
  input  logic             op_wide,
  output logic             stall,
  output logic [2:0]       busy,
  output logic             res_vld,
  output logic [CNT_W-1:0] res_lat
);

  logic [NRES-1:0]            unit_sel;
  logic [CNT_W-1:0]           dec_occ;
  logic [CNT_W-1:0]           dec_lat;
  logic [NRES-1:0]            unit_busy;
  logic [NRES-1:0][CNT_W-1:0] cnt_all;
  logic                       accept;

  itr_occ_decode #(
    .CNT_W(CNT_W),
    .IDIV_N_CYC(IDIV_N_CYC), .IDIV_W_CYC(IDIV_W_CYC),
    .IMUL_N_CYC(IMUL_N_CYC), .IMUL_N_LAT(IMUL_N_LAT),
    .IMUL_W_CYC(IMUL_W_CYC), .IMUL_W_LAT(IMUL_W_LAT),
    .IMUL3_HOLD(IMUL3_HOLD), .IMUL3_LAT(IMUL3_LAT),
    .FDIV_S_CYC(FDIV_S_CYC), .FDIV_D_CYC(FDIV_D_CYC),
    .FRSQ_S_CYC(FRSQ_S_CYC), .FRSQ_D_CYC(FRSQ_D_CYC),
    .FMUL_S_CYC(FMUL_S_CYC), .FMUL_S_LAT(FMUL_S_LAT),
    .FMUL_D_CYC(FMUL_D_CYC), .FMUL_D_LAT(FMUL_D_LAT),
    .MTPR_LAT(MTPR_LAT), .MFPR_LAT(MFPR_LAT)
  ) u_dec (
    .opc     (op_class),
    .wide    (op_wide),
    .unit_sel(unit_sel),
    .occ     (dec_occ),
    .lat     (dec_lat)
  );

  assign stall  = op_start && ((unit_sel & unit_busy) != '0);
  assign accept = op_start && !stall;

  for (genvar i = 0; i < NRES; i++) begin : g_unit
    itr_occ_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .load    (accept && unit_sel[i]),
      .load_val(dec_occ),
      .cnt     (cnt_all[i]),
      .busy    (unit_busy[i])
    );
  end

  assign busy = unit_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld <= 1'b0;
      res_lat <= '0;
    end else begin
      res_vld <= accept;
      if (accept)
        res_lat <= dec_lat;
    end
  end

endmodule

// File: rtl/itr_occ_checker.sv
module itr_occ_checker #(
  parameter int NRES  = 3,
  parameter int CNT_W = 7
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       op_start,
  input logic [2:0]                 op_class,
  input logic                       stall,
  input logic [NRES-1:0]            busy,
  input logic                       res_vld,
  input logic [NRES-1:0][CNT_W-1:0] cnt_all
);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (busy == '0) && !res_vld);

  p_stall_needs_busy_r9: assert property (@(posedge clk) disable iff (rst)
    stall |-> op_start && (busy != '0));

  p_stall_no_report_r9: assert property (@(posedge clk) disable iff (rst)
    stall |=> !res_vld);

  for (genvar i = 0; i < NRES; i++) begin : g_cd
    p_count_down_r9: assert property (@(posedge clk) disable iff (rst)
      (cnt_all[i] != '0) |=> cnt_all[i] == $past(cnt_all[i]) - CNT_W'(1));
  end

  p_idle_no_stall_r10: assert property (@(posedge clk) disable iff (rst)
    (busy == '0) |-> !stall);

  p_moves_never_stall_r8: assert property (@(posedge clk) disable iff (rst)
    op_start && (op_class >= 3'd6) |-> !stall);

  p_report_after_accept_r11: assert property (@(posedge clk) disable iff (rst)
    op_start && !stall |=> res_vld);

  p_no_spurious_report_r11: assert property (@(posedge clk) disable iff (rst)
    !(op_start && !stall) |=> !res_vld);

endmodule

bind itr_occ_tracker itr_occ_checker #(.NRES(itr_occ_pkg::NRES), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .op_start(op_start),
  .op_class(op_class),
  .stall   (stall),
  .busy    (busy),
  .res_vld (res_vld),
  .cnt_all (cnt_all)
);

// File: tb/test_itr_occ_tracker.sv
module test_itr_occ_tracker;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_start = 1'b0;
  logic [2:0] op_class = '0;
  logic       op_wide = 1'b0;
  logic       stall;
  logic [2:0] busy;
  logic       res_vld;
  logic [6:0] res_lat;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  itr_occ_tracker i_itr_occ_tracker (
    .clk(clk), .rst(rst), .op_start(op_start), .op_class(op_class),
    .op_wide(op_wide), .stall(stall), .busy(busy), .res_vld(res_vld),
    .res_lat(res_lat)
  );

  function automatic int exp_occ(int op, bit w);
    case (op)
      0: return w ? 68 : 36;
      1: return w ? 8 : 3;
      2: return w ? 8 : 2;
      3: return w ? 36 : 21;
      4: return w ? 68 : 38;
      5: return w ? 2 : 1;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_lat(int op, bit w);
    case (op)
      0: return w ? 68 : 36;
      1: return w ? 9 : 5;
      2: return w ? 9 : 2;
      3: return w ? 36 : 21;
      4: return w ? 68 : 38;
      5: return w ? 5 : 4;
      6: return 3;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_mask(int op);
    case (op)
      0, 1, 2: return 1;
      3, 4:    return 4;
      5:       return 2;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    op_start = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  // Presents one request for a full cycle starting just after a falling edge.
  task automatic pulse(input int op, input bit w, output bit st);
    op_start = 1'b1;
    op_class = 3'(op);
    op_wide  = w;
    #1 st = stall;
    @(negedge clk);
    op_start = 1'b0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog R1..: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit st;
    int n;
    @(negedge clk);
    do_reset();
    chk(busy == 3'b000, "R1", "busy after reset", int'(busy), 0);
    chk(res_vld == 1'b0, "R1", "res_vld after reset", int'(res_vld), 0);

    // Reset applied while a resource is occupied.
    pulse(0, 1'b1, st);
    chk(busy == 3'b001, "R2", "busy before reset", int'(busy), 1);
    repeat (3) @(negedge clk);
    do_reset();
    chk(busy == 3'b000, "R1", "busy cleared by reset", int'(busy), 0);
    chk(res_vld == 1'b0, "R1", "res_vld cleared", int'(res_vld), 0);

    // Sweep every class at both sizes from idle.
    for (int op = 0; op < 8; op++) begin
      for (int w = 0; w < 2; w++) begin
        do_reset();
        pulse(op, w[0], st);
        chk(st == 1'b0, "R10", "idle request stalled", int'(st), 0);
        chk(res_vld == 1'b1, "R11", "report after accept", int'(res_vld), 1);
        chk(int'(res_lat) == exp_lat(op, w[0]), req_of(op), "latency",
            int'(res_lat), exp_lat(op, w[0]));
        chk(int'(busy) == (exp_occ(op, w[0]) > 0 ? exp_mask(op) : 0),
            req_of(op), "busy mask", int'(busy),
            exp_occ(op, w[0]) > 0 ? exp_mask(op) : 0);
        n = 0;
        for (int k = 0; k < 200; k++) begin
          pulse(op, w[0], st);
          if (!st) break;
          n++;
          chk(res_vld == 1'b0, "R9", "report after stalled request",
              int'(res_vld), 0);
        end
        chk(n == exp_occ(op, w[0]), req_of(op), "stalled cycles (occupancy)",
            n, exp_occ(op, w[0]));
        chk(res_vld == 1'b1, "R11", "report after release", int'(res_vld), 1);
      end
    end

    // Independence: hold the integer iterator and use the others.
    do_reset();
    pulse(0, 1'b1, st);
    pulse(5, 1'b0, st);
    chk(st == 1'b0, "R10", "FP multiply during integer divide", int'(st), 0);
    pulse(3, 1'b1, st);
    chk(st == 1'b0, "R10", "FP divide during integer divide", int'(st), 0);
    chk(busy == 3'b101, "R10", "busy mask after FP multiply drained",
        int'(busy), 5);
    pulse(1, 1'b0, st);
    chk(st == 1'b1, "R9", "integer multiply during integer divide", int'(st), 1);
    chk(res_vld == 1'b0, "R9", "no report after stall", int'(res_vld), 0);
    pulse(6, 1'b0, st);
    chk(st == 1'b0, "R8", "move-in while units busy", int'(st), 0);
    chk(int'(res_lat) == 3, "R8", "move-in latency", int'(res_lat), 3);
    pulse(7, 1'b0, st);
    chk(st == 1'b0, "R8", "move-out while units busy", int'(st), 0);
    chk(int'(res_lat) == 1, "R8", "move-out latency", int'(res_lat), 1);
    pulse(4, 1'b0, st);
    chk(st == 1'b1, "R9", "rsqrt during FP divide", int'(st), 1);
    @(negedge clk);
    #1;
    chk(res_vld == 1'b0, "R11", "report is one cycle only", int'(res_vld), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule